// File: doc/BRIEF.md
# RAM Section Power and Retention Control

This block holds one 32-bit control word for each RAM block of a chip. Each word carries a power enable and a retention enable for each of the block's sixteen sections. Software reaches each word through three word-aligned aliases on a simple register bus:

- a plain read/write alias;
- an alias where every 1 written switches the matching bit on;
- an alias where every 1 written switches the matching bit off.

A system-mode input tells the block whether the chip is running (ON) or sleeping (OFF). The stored bits and that mode are decoded into two per-section status outputs. One says whether the section is usable by the bus fabric. The other says whether its contents are kept.

The number of implemented RAM blocks is a parameter. Addresses that fall in the register window but belong to a missing block read as zero, and writes to them are dropped. So do addresses that hit no alias. The RAM macros and the analog power switches sit outside this block and consume the status outputs.

Top module: `ram_pwr_ctrl`

## Requirements
- R1: After reset every implemented block's word reads 0x0000FFFF: all sections powered, no retention. Block n's plain alias sits at byte offset 0x600 + n*0x10.
- R2: A write to the plain alias (offset +0x0) replaces the whole word. Bit i (0..15) is the power enable of section i. Bit 16+i is the retention enable of section i.
- R3: A write to the set alias (offset +0x4) turns on exactly the bits written as 1 and leaves the other bits unchanged.
- R4: A write to the clear alias (offset +0x8) turns off exactly the bits written as 1 and leaves the other bits unchanged.
- R5: A read of the set alias or the clear alias returns the current stored word.
- R6: With sys_on = 0, no section is accessible. Section i is retained exactly when its retention bit is 1. The status output index for block n, section i is n*16+i.
- R7: With sys_on = 1 and the power bit of a section at 1, that section is both accessible and retained, whatever its retention bit is.
- R8: With sys_on = 1 and the power bit of a section at 0, that section is not accessible. It is retained exactly when its retention bit is 1.
- R9: Any address that is not one of the three word-aligned aliases of a block reads as zero, and writes to it change no stored word. This includes alias +0xC, addresses outside 0x600..0x67F, and unaligned addresses.
- R10: Addresses of blocks at or above NUM_BLK read as zero, and writes to them change no stored word.
- R11: A write takes effect at the clock edge that samples it: during the write cycle the old value is read, and the new value afterwards. The status outputs follow sys_on and the stored word with no clock delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| arst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| sys_on | input | 1 | System mode: 1 = running, 0 = sleeping |
| bus_sel | input | 1 | Bus access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational, zero when not selected or not decoded |
| sec_access | output | NUM_BLK*16 | Per-section accessible status |
| sec_retain | output | NUM_BLK*16 | Per-section retained status |

## Verification
The bench applies set and clear patterns whose 1s and 0s overlap bits that are already set and bits that are already clear. A design that applied an alias as a plain write, or inverted the mask, would show altered neighbour bits on read-back. Status checks are made in both modes on words that mix powered-without-retention sections with unpowered-with-retention sections. These catch a decode that lets retention depend on power while asleep, or that grants access while sleeping. The bench writes to alias +0xC, to an address just outside the window, to an unaligned address and to a missing block, then reads the neighbouring words. An over-wide decoder would corrupt them. It also checks the old-value read during the write cycle, an instant status change on a mode flip, and the asynchronous return to the reset word.

// File: rtl/rpc_pkg.sv
package rpc_pkg;
  localparam int SEC_PER_BLK = 16;
  localparam int WORD_W      = 2 * SEC_PER_BLK;
  localparam int MAX_BLK     = 8;
  localparam int BLK_IDX_W   = $clog2(MAX_BLK);
  localparam logic [11:0] WIN_BASE = 12'h600;
  localparam logic [WORD_W-1:0] RESET_WORD =
    {{SEC_PER_BLK{1'b0}}, {SEC_PER_BLK{1'b1}}};

  typedef enum logic [1:0] {
    ALIAS_DIRECT = 2'd0,
    ALIAS_SET    = 2'd1,
    ALIAS_CLR    = 2'd2,
    ALIAS_NONE   = 2'd3
  } alias_e;
endpackage

// File: rtl/rpc_rst_sync.sv
module rpc_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) stage_q <= 2'b00;
    else         stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_n_o = stage_q[1];
endmodule

// File: rtl/rpc_decode.sv
module rpc_decode
  import rpc_pkg::*;
#(
  parameter int NUM_BLK = 4,
  parameter int ADDR_W  = 12
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bus_sel,
  input  logic                 bus_wr,
  input  logic [ADDR_W-1:0]    bus_addr,
  output logic [NUM_BLK-1:0]   wr_dir,
  output logic [NUM_BLK-1:0]   wr_set,
  output logic [NUM_BLK-1:0]   wr_clr,
  output logic                 rd_hit,
  output logic [BLK_IDX_W-1:0] rd_idx
);
  localparam logic [ADDR_W-1:0] BASE_A = ADDR_W'(WIN_BASE);

  logic                 in_window;
  logic                 aligned;
  logic                 implemented;
  logic                 alias_ok;
  logic                 hit;
  logic [BLK_IDX_W-1:0] blk;
  alias_e               kind;

  always_comb begin
    blk         = bus_addr[4 +: BLK_IDX_W];
    kind        = alias_e'(bus_addr[3:2]);
    in_window   = (bus_addr[ADDR_W-1:7] == BASE_A[ADDR_W-1:7]);
    aligned     = (bus_addr[1:0] == 2'b00);
    implemented = (int'(blk) < NUM_BLK);
    alias_ok    = (kind != ALIAS_NONE);
    hit         = bus_sel & in_window & aligned & implemented & alias_ok;
  end

  assign rd_hit = hit & ~bus_wr;
  assign rd_idx = blk;

  for (genvar b = 0; b < NUM_BLK; b++) begin : g_strobe
    logic this_blk;
    assign this_blk  = hit & bus_wr & (blk == BLK_IDX_W'(b));
    assign wr_dir[b] = this_blk & (kind == ALIAS_DIRECT);
    assign wr_set[b] = this_blk & (kind == ALIAS_SET);
    assign wr_clr[b] = this_blk & (kind == ALIAS_CLR);
  end

  // R9
  strobe_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({wr_dir, wr_set, wr_clr}));

  // R10
  unimpl_nohit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !implemented) |-> (!rd_hit && ({wr_dir, wr_set, wr_clr} == '0)));
endmodule

// File: rtl/rpc_block_reg.sv
module rpc_block_reg
  import rpc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_dir,
  input  logic              wr_set,
  input  logic              wr_clr,
  input  logic [WORD_W-1:0] wdata,
  output logic [WORD_W-1:0] word_q
);
  logic [WORD_W-1:0] word_nxt;
  logic              word_en;

  always_comb begin
    word_en  = wr_dir | wr_set | wr_clr;
    word_nxt = word_q;
    if (wr_dir)      word_nxt = wdata;
    else if (wr_set) word_nxt = word_q | wdata;
    else if (wr_clr) word_nxt = word_q & ~wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       word_q <= RESET_WORD;
    else if (word_en) word_q <= word_nxt;
  end

  // R2
  direct_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_dir |=> (word_q == $past(wdata)));

  // R3
  set_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_set |=> (((word_q & $past(wdata)) == $past(wdata)) &&
                ((word_q & ~$past(wdata)) == ($past(word_q) & ~$past(wdata)))));

  // R4
  clr_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_clr |=> (((word_q & $past(wdata)) == '0) &&
                ((word_q & ~$past(wdata)) == ($past(word_q) & ~$past(wdata)))));

  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_dir || wr_set || wr_clr) |=> $stable(word_q));
endmodule

// File: rtl/rpc_status.sv
module rpc_status
  import rpc_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   sys_on,
  input  logic [WORD_W-1:0]      word,
  output logic [SEC_PER_BLK-1:0] access,
  output logic [SEC_PER_BLK-1:0] retain
);
  logic [SEC_PER_BLK-1:0] pwr_en;
  logic [SEC_PER_BLK-1:0] ret_en;

  assign pwr_en = word[SEC_PER_BLK-1:0];
  assign ret_en = word[WORD_W-1:SEC_PER_BLK];

  for (genvar s = 0; s < SEC_PER_BLK; s++) begin : g_sec
    always_comb begin
      access[s] = sys_on & pwr_en[s];
      retain[s] = ret_en[s] | (sys_on & pwr_en[s]);
    end
  end

  // R6
  off_noaccess_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sys_on |-> ((access == '0) && (retain == ret_en)));

  // R7
  on_powered_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sys_on |-> (((access & pwr_en) == pwr_en) && ((retain & pwr_en) == pwr_en)));

  // R8
  on_unpowered_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sys_on |-> (((access & ~pwr_en) == '0) && ((retain & ~pwr_en) == (ret_en & ~pwr_en))));
endmodule

// File: rtl/ram_pwr_ctrl.sv
module ram_pwr_ctrl
  import rpc_pkg::*;
#(
  parameter int NUM_BLK = 4,
  parameter int ADDR_W  = 12
) (
  input  logic                           clk,
  input  logic                           arst_n,
  input  logic                           sys_on,
  input  logic                           bus_sel,
  input  logic                           bus_wr,
  input  logic [ADDR_W-1:0]              bus_addr,
  input  logic [WORD_W-1:0]              bus_wdata,
  output logic [WORD_W-1:0]              bus_rdata,
  output logic [NUM_BLK*SEC_PER_BLK-1:0] sec_access,
  output logic [NUM_BLK*SEC_PER_BLK-1:0] sec_retain
);
  logic                 rst_n;
  logic [NUM_BLK-1:0]   wr_dir;
  logic [NUM_BLK-1:0]   wr_set;
  logic [NUM_BLK-1:0]   wr_clr;
  logic                 rd_hit;
  logic [BLK_IDX_W-1:0] rd_idx;
  logic [WORD_W-1:0]    words [NUM_BLK];

  rpc_rst_sync u_rst (
    .clk     (clk),
    .arst_n  (arst_n),
    .rst_n_o (rst_n)
  );

  rpc_decode #(.NUM_BLK(NUM_BLK), .ADDR_W(ADDR_W)) u_dec (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_sel  (bus_sel),
    .bus_wr   (bus_wr),
    .bus_addr (bus_addr),
    .wr_dir   (wr_dir),
    .wr_set   (wr_set),
    .wr_clr   (wr_clr),
    .rd_hit   (rd_hit),
    .rd_idx   (rd_idx)
  );

  for (genvar b = 0; b < NUM_BLK; b++) begin : g_blk
    rpc_block_reg u_reg (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_dir (wr_dir[b]),
      .wr_set (wr_set[b]),
      .wr_clr (wr_clr[b]),
      .wdata  (bus_wdata),
      .word_q (words[b])
    );

    rpc_status u_stat (
      .clk    (clk),
      .rst_n  (rst_n),
      .sys_on (sys_on),
      .word   (words[b]),
      .access (sec_access[b*SEC_PER_BLK +: SEC_PER_BLK]),
      .retain (sec_retain[b*SEC_PER_BLK +: SEC_PER_BLK])
    );
  end

  always_comb begin
    bus_rdata = '0;
    for (int b = 0; b < NUM_BLK; b++) begin
      if (rd_hit && (rd_idx == BLK_IDX_W'(b))) bus_rdata = words[b];
    end
  end

  // R9
  miss_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_hit |-> (bus_rdata == '0));
endmodule

// File: tb/ram_pwr_ctrl_bench.sv
module ram_pwr_ctrl_bench;
  localparam int NB  = 4;
  localparam int AW  = 12;
  localparam int SEC = 16;

  logic            clk = 1'b0;
  logic            arst_n;
  logic            sys_on;
  logic            bus_sel;
  logic            bus_wr;
  logic [AW-1:0]   bus_addr;
  logic [31:0]     bus_wdata;
  logic [31:0]     bus_rdata;
  logic [NB*SEC-1:0] sec_access;
  logic [NB*SEC-1:0] sec_retain;

  int n_chk = 0;
  int n_err = 0;
  logic [31:0] mdl [NB];

  ram_pwr_ctrl #(.NUM_BLK(NB), .ADDR_W(AW)) u_ram_pwr_ctrl (
    .clk(clk), .arst_n(arst_n), .sys_on(sys_on), .bus_sel(bus_sel),
    .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .sec_access(sec_access), .sec_retain(sec_retain)
  );

  always #5 clk = ~clk;

  // {address, write data, expected word of the addressed block afterwards}
  localparam logic [75:0] VEC [8] = '{
    {12'h600, 32'h1234_5678, 32'h1234_5678},  // R2 plain write
    {12'h604, 32'h0001_0080, 32'h1235_56F8},  // R3 set
    {12'h608, 32'h1000_0008, 32'h0235_56F0},  // R4 clear
    {12'h614, 32'hFFFF_0000, 32'hFFFF_FFFF},  // R3 set blk1
    {12'h618, 32'h0000_FFFF, 32'hFFFF_0000},  // R4 clear blk1
    {12'h630, 32'hA5A5_5A5A, 32'hA5A5_5A5A},  // R2 blk3
    {12'h638, 32'hFFFF_FFFF, 32'h0000_0000},  // R4 clear all blk3
    {12'h624, 32'h0000_0000, 32'h0000_FFFF}   // R3 set nothing blk2
  };

  task automatic check(input logic [63:0] act, input logic [63:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [AW-1:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic bus_read_chk(input logic [AW-1:0] a, input logic [31:0] e, input string tag);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1;
    check(64'(bus_rdata), 64'(e), tag);
    bus_sel = 1'b0;
  endtask

  task automatic status_chk();
    for (int b = 0; b < NB; b++) begin
      logic [15:0] p, r;
      p = mdl[b][15:0];
      r = mdl[b][31:16];
      if (sys_on) begin
        check(64'(sec_access[b*SEC +: SEC] & p), 64'(p), "R7 powered access");
        check(64'(sec_retain[b*SEC +: SEC] & p), 64'(p), "R7 powered retain");
        check(64'(sec_access[b*SEC +: SEC] & ~p), 64'(0), "R8 unpowered access");
        check(64'(sec_retain[b*SEC +: SEC] & ~p), 64'(r & ~p), "R8 unpowered retain");
      end else begin
        check(64'(sec_access[b*SEC +: SEC]), 64'(0), "R6 off access");
        check(64'(sec_retain[b*SEC +: SEC]), 64'(r), "R6 off retain");
      end
    end
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin : main
    arst_n = 1'b0; sys_on = 1'b1; bus_sel = 1'b0; bus_wr = 1'b0;
    bus_addr = '0; bus_wdata = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) arst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    for (int b = 0; b < NB; b++) begin
      mdl[b] = 32'h0000_FFFF;
      bus_read_chk(AW'(12'h600 + b*16), 32'h0000_FFFF, "R1 reset word");
    end
    check(64'(sec_access), {NB*SEC{1'b1}}, "R1 reset access all");
    check(64'(sec_retain), {NB*SEC{1'b1}}, "R1 reset retain all");

    // Vector table: R2 R3 R4 R5
    for (int v = 0; v < 8; v++) begin
      logic [AW-1:0] a;
      int bi;
      a  = VEC[v][75:64];
      bi = int'(a[6:4]);
      bus_write(a, VEC[v][63:32]);
      mdl[bi] = VEC[v][31:0];
      bus_read_chk(AW'(12'h600 + bi*16), VEC[v][31:0], "R2/R3/R4 vector word");
      bus_read_chk(AW'(12'h604 + bi*16), VEC[v][31:0], "R5 set alias read");
      bus_read_chk(AW'(12'h608 + bi*16), VEC[v][31:0], "R5 clear alias read");
    end

    // Status decode in both modes
    @(negedge clk) sys_on = 1'b1; #1;
    status_chk();
    @(negedge clk) sys_on = 1'b0; #1;
    status_chk();
    @(negedge clk) sys_on = 1'b1;

    // R9 undecoded addresses
    bus_write(12'h60C, 32'hFFFF_FFFF);
    bus_read_chk(12'h60C, 32'h0, "R9 alias +0xC reads zero");
    bus_write(12'h680, 32'h0);
    bus_read_chk(12'h680, 32'h0, "R9 outside window reads zero");
    bus_write(12'h5F0, 32'h0);
    bus_write(12'h601, 32'h0);
    bus_read_chk(12'h601, 32'h0, "R9 unaligned reads zero");
    for (int b = 0; b < NB; b++)
      bus_read_chk(AW'(12'h600 + b*16), mdl[b], "R9 words untouched");

    // R10 missing blocks
    bus_write(12'h640, 32'h0);
    bus_write(12'h674, 32'hFFFF_FFFF);
    bus_read_chk(12'h640, 32'h0, "R10 missing block reads zero");
    bus_read_chk(12'h674, 32'h0, "R10 missing set alias reads zero");
    for (int b = 0; b < NB; b++)
      bus_read_chk(AW'(12'h600 + b*16), mdl[b], "R10 words untouched");

    // R11 write timing: old value during write cycle, new after edge
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 12'h600; bus_wdata = 32'hDEAD_0000;
    #1 check(64'(u_ram_pwr_ctrl.bus_rdata), 64'(0), "R11 no read data while writing");
    bus_wr = 1'b0;
    #1 check(64'(bus_rdata), 64'(mdl[0]), "R11 old value before edge");
    bus_wr = 1'b1;
    @(posedge clk); #1;
    bus_wr = 1'b0;
    #1 check(64'(bus_rdata), 64'hDEAD_0000, "R11 new value after edge");
    bus_sel = 1'b0;
    mdl[0] = 32'hDEAD_0000;

    // R11 combinational status on mode flip mid-cycle
    @(posedge clk); #2;
    sys_on = 1'b0;
    #1 check(64'(sec_retain[15:0]), 64'hDEAD, "R11 R6 retain follows mode at once");
    check(64'(sec_access[15:0]), 64'h0, "R11 R6 access follows mode at once");
    sys_on = 1'b1;
    #1 check(64'(sec_access[31:16]), 64'(mdl[1][15:0]), "R11 R7 access back on");

    // R1 asynchronous return to reset word
    @(negedge clk);
    arst_n = 1'b0;
    bus_sel = 1'b0; bus_wr = 1'b0;
    #1;
    check(64'(sec_access), {NB*SEC{1'b1}}, "R1 async reset access");
    check(64'(sec_retain), {NB*SEC{1'b1}}, "R1 async reset retain");
    @(negedge clk) arst_n = 1'b1;
    repeat (3) @(negedge clk);
    bus_read_chk(12'h630, 32'h0000_FFFF, "R1 word after second reset");

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule